// File: doc/BRIEF.md
# Peripheral Clock-Enable and Reset Sequencer

This block controls one peripheral channel: a clock-enable output and a reset output. When it gets an enable request, it brings the peripheral up in a safe order. First it holds the peripheral in reset and waits a short settling time. Then it starts the clock and waits a much longer time. Only after that does it release reset. A disable request stops the clock at once and leaves the reset line as it is. Both waits are parameters in nanoseconds. The block turns them into clock cycles using its clock-frequency parameter.

A channel counts as enabled only when its clock runs and its reset is released. A clock that runs while reset is held does not count as enabled, so a request in that state runs the full sequence. A channel built without a reset line only switches its clock, with no waits. Its reset output then stays low, and the system handles the peripheral's reset somewhere else. The sequencer takes a request only when `ready_o` is high. It holds `busy_o` high until it finishes, and it marks completion with a one-cycle `done_o` pulse.

Top module: `clkrst_seq`

## Requirements
- R1: After `rst_ni` is low, the outputs are `ready_o`=1, `busy_o`=0 and `done_o`=0. `clk_en_o` equals the parameter CLK_INIT. `periph_rst_o` is 1 on a channel with a reset line (HAS_RST=1) and 0 on a channel without one.
- R2: Enable is taken at edge E0 on a channel with a reset line that is not enabled. `periph_rst_o` is high after E1. `clk_en_o` is high after E(2+S), where S is the short wait in cycles. So reset is held for at least S cycles before the clock starts.
- R3: In the same sequence, `periph_rst_o` falls after E(3+S+L), where L is the long wait in cycles. `done_o` is high in that same cycle, and `clk_en_o` stays high.
- R4: An enable request on an enabled channel (`clk_en_o`=1 and `periph_rst_o`=0) changes neither output. It gives `done_o` in the cycle right after the accepting edge.
- R5: An enable request where `clk_en_o`=1 but `periph_rst_o`=1 runs the full sequence with the same timing as R3. `clk_en_o` stays high the whole time.
- R6: On a channel without a reset line, an enable request sets `clk_en_o` and `done_o` after E1, with no waits. `periph_rst_o` stays 0 at all times.
- R7: A disable request clears `clk_en_o` after the accepting edge and pulses `done_o` in that cycle. `periph_rst_o` does not change.
- R8: `done_o` lasts exactly one cycle. After it, `ready_o` is 1 again.
- R9: From the accepting edge until the done cycle, `ready_o`=0 and `busy_o`=1. Requests that arrive in that window are ignored.
- R10: If enable and disable are requested in the same cycle, disable wins.
- R11: A wait of T ns at F Hz lasts ceil(T*F/1e9) cycles, and never less than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_req_i | input | 1 | Enable request, sampled while ready |
| dis_req_i | input | 1 | Disable request, sampled while ready; wins over enable |
| ready_o | output | 1 | Idle and able to accept a request |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| clk_en_o | output | 1 | Peripheral clock enable |
| periph_rst_o | output | 1 | Peripheral reset, active high |

## Verification
Every result is due at a fixed edge counted from the accepting edge E0. A disable, or an enable on an already enabled channel, shows after E0. The clock on a channel without a reset line shows after E1. The reset assertion shows after E1, the clock start after E(2+S), and the reset release with done after E(3+S+L). The driver turns each of these edge numbers into a cycle index and queues the expected outputs under that index before it raises the request. The monitor samples on the falling edge, so it reads settled outputs. It compares a queued item only when the cycle counter reaches that item's index, and it reports any item it passed without checking.

// File: rtl/clkrst_seq_pkg.sv
package clkrst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE        = 3'd0,
    ST_RST_ASSERT  = 3'd1,
    ST_WAIT_SHORT  = 3'd2,
    ST_CLK_ON      = 3'd3,
    ST_WAIT_LONG   = 3'd4,
    ST_RST_RELEASE = 3'd5,
    ST_DONE        = 3'd6
  } seq_state_e;

  // Cycles covering a delay of ns nanoseconds at hz, rounded up, at least one.
  function automatic int delay_cycles(input int hz, input int ns);
    longint prod;
    longint cyc;
    prod = longint'(hz) * longint'(ns);
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc < 1) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/clkrst_seq_timer.sv
module clkrst_seq_timer #(
  parameter int SHORT_CYC = 2,
  parameter int LONG_CYC  = 4,
  localparam int CNT_W    = $clog2(clkrst_seq_pkg::max_int(SHORT_CYC, LONG_CYC) + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic long_i,
  output logic hit_o
);

  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = !clr_i && (cnt_q == (long_i ? LONG_LAST : SHORT_LAST));

endmodule

// File: rtl/clkrst_seq_ctrl.sv
module clkrst_seq_ctrl
  import clkrst_seq_pkg::*;
#(
  parameter bit HAS_RST  = 1'b1,
  parameter bit CLK_INIT = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_req_i,
  input  logic       dis_req_i,
  input  logic       timer_hit_i,
  output seq_state_e state_o,
  output logic       timer_clr_o,
  output logic       timer_long_o,
  output logic       clk_en_o,
  output logic       periph_rst_o
);

  seq_state_e state_q, state_d;

  // Named internal events
  logic is_enabled;
  logic take_dis;
  logic take_en;
  logic ev_gate_on;
  logic ev_gate_off;
  logic ev_rst_set;
  logic ev_rst_clr;

  assign is_enabled  = clk_en_o && !periph_rst_o;
  assign take_dis    = (state_q == ST_IDLE) && dis_req_i;
  assign take_en     = (state_q == ST_IDLE) && en_req_i && !dis_req_i;
  assign ev_gate_on  = (state_q == ST_CLK_ON);
  assign ev_gate_off = take_dis;
  assign ev_rst_set  = (state_q == ST_RST_ASSERT);
  assign ev_rst_clr  = (state_q == ST_RST_RELEASE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take_dis)                state_d = ST_DONE;
        else if (take_en) begin
          if (is_enabled)            state_d = ST_DONE;
          else if (HAS_RST)          state_d = ST_RST_ASSERT;
          else                       state_d = ST_CLK_ON;
        end
      end
      ST_RST_ASSERT:                 state_d = ST_WAIT_SHORT;
      ST_WAIT_SHORT:  if (timer_hit_i) state_d = ST_CLK_ON;
      ST_CLK_ON:                     state_d = HAS_RST ? ST_WAIT_LONG : ST_DONE;
      ST_WAIT_LONG:   if (timer_hit_i) state_d = ST_RST_RELEASE;
      ST_RST_RELEASE:                state_d = ST_DONE;
      ST_DONE:                       state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          clk_en_o <= CLK_INIT;
    else if (ev_gate_off) clk_en_o <= 1'b0;
    else if (ev_gate_on)  clk_en_o <= 1'b1;
  end

  generate
    if (HAS_RST) begin : g_rst
      logic prst_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         prst_q <= 1'b1;
        else if (ev_rst_set) prst_q <= 1'b1;
        else if (ev_rst_clr) prst_q <= 1'b0;
      end
      assign periph_rst_o = prst_q;
    end else begin : g_norst
      assign periph_rst_o = 1'b0;
    end
  endgenerate

  assign state_o      = state_q;
  assign timer_clr_o  = !((state_q == ST_WAIT_SHORT) || (state_q == ST_WAIT_LONG));
  assign timer_long_o = (state_q == ST_WAIT_LONG);

endmodule

// File: rtl/clkrst_seq.sv
module clkrst_seq
  import clkrst_seq_pkg::*;
#(
  parameter bit HAS_RST  = 1'b1,
  parameter bit CLK_INIT = 1'b0,
  parameter int CLK_HZ   = 100_000_000,
  parameter int SHORT_NS = 100_000,
  parameter int LONG_NS  = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_req_i,
  input  logic dis_req_i,
  output logic ready_o,
  output logic busy_o,
  output logic done_o,
  output logic clk_en_o,
  output logic periph_rst_o
);

  localparam int SHORT_CYC = delay_cycles(CLK_HZ, SHORT_NS);
  localparam int LONG_CYC  = delay_cycles(CLK_HZ, LONG_NS);

  seq_state_e state;
  logic       timer_clr;
  logic       timer_long;
  logic       timer_hit;

  clkrst_seq_ctrl #(
    .HAS_RST  (HAS_RST),
    .CLK_INIT (CLK_INIT)
  ) ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_req_i     (en_req_i),
    .dis_req_i    (dis_req_i),
    .timer_hit_i  (timer_hit),
    .state_o      (state),
    .timer_clr_o  (timer_clr),
    .timer_long_o (timer_long),
    .clk_en_o     (clk_en_o),
    .periph_rst_o (periph_rst_o)
  );

  clkrst_seq_timer #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (timer_clr),
    .long_i (timer_long),
    .hit_o  (timer_hit)
  );

  assign ready_o = (state == ST_IDLE);
  assign busy_o  = (state != ST_IDLE);
  assign done_o  = (state == ST_DONE);

endmodule

// File: rtl/clkrst_seq_chk.sv
module clkrst_seq_chk #(
  parameter bit HAS_RST   = 1'b1,
  parameter int SHORT_CYC = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_req_i,
  input logic dis_req_i,
  input logic ready_o,
  input logic busy_o,
  input logic done_o,
  input logic clk_en_o,
  input logic periph_rst_o
);

  // Cycles spent with reset held and the clock stopped (saturating)
  logic [31:0] hold_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      hold_cnt <= '0;
    else if (periph_rst_o && !clk_en_o) begin
      if (hold_cnt != 32'hFFFF_FFFF) hold_cnt <= hold_cnt + 1'b1;
    end else                          hold_cnt <= '0;
  end

  a_r2_reset_before_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_RST && $rose(clk_en_o)) |-> (periph_rst_o && (hold_cnt >= SHORT_CYC)));

  a_r3_release_with_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(periph_rst_o) |-> (clk_en_o && done_o));

  a_r4_enabled_done_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && en_req_i && !dis_req_i && clk_en_o && !periph_rst_o)
      |=> (done_o && clk_en_o && !periph_rst_o));

  a_r6_no_reset_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_RST == 1'b0) |-> !periph_rst_o);

  a_r7_disable_keeps_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && dis_req_i) |=> (!clk_en_o && $stable(periph_rst_o) && done_o));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));

  a_r9_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  a_r9_gate_off_only_on_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> $past(ready_o && dis_req_i));

  a_r10_disable_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && en_req_i && dis_req_i) |=> !clk_en_o);

endmodule

bind clkrst_seq clkrst_seq_chk #(
  .HAS_RST   (HAS_RST),
  .SHORT_CYC (SHORT_CYC)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_req_i     (en_req_i),
  .dis_req_i    (dis_req_i),
  .ready_o      (ready_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .clk_en_o     (clk_en_o),
  .periph_rst_o (periph_rst_o)
);

// File: tb/clkrst_seq_tb_top.sv
module clkrst_seq_tb_top;

  // R11: 50 ns and 120 ns at 100 MHz -> ceil(5.0)=5 and ceil(12.0)=12 cycles
  localparam int HZ  = 100_000_000;
  localparam int SNS = 50;
  localparam int LNS = 120;
  localparam int S   = (SNS * (HZ / 1_000_000) + 999) / 1000;
  localparam int L   = (LNS * (HZ / 1_000_000) + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic en0 = 1'b0, dis0 = 1'b0, en1 = 1'b0, dis1 = 1'b0;
  logic rdy0, bsy0, dn0, ce0, pr0;
  logic rdy1, bsy1, dn1, ce1, pr1;

  // Channel with reset line, clock running out of reset
  clkrst_seq #(.HAS_RST(1'b1), .CLK_INIT(1'b1), .CLK_HZ(HZ), .SHORT_NS(SNS), .LONG_NS(LNS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en0), .dis_req_i(dis0),
    .ready_o(rdy0), .busy_o(bsy0), .done_o(dn0), .clk_en_o(ce0), .periph_rst_o(pr0));

  // Channel without reset line
  clkrst_seq #(.HAS_RST(1'b0), .CLK_INIT(1'b0), .CLK_HZ(HZ), .SHORT_NS(SNS), .LONG_NS(LNS)) dut_nr_i (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en1), .dis_req_i(dis1),
    .ready_o(rdy1), .busy_o(bsy1), .done_o(dn1), .clk_en_o(ce1), .periph_rst_o(pr1));

  typedef struct {
    int    cyc;
    int    which;
    bit    ce, pr, dn, rdy;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares queued expectations when their cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      logic ace, apr, adn, ardy, absy;
      e = q.pop_front();
      checks++;
      if (e.which == 0) begin ace = ce0; apr = pr0; adn = dn0; ardy = rdy0; absy = bsy0; end
      else              begin ace = ce1; apr = pr1; adn = dn1; ardy = rdy1; absy = bsy1; end
      if (e.cyc < cyc) begin
        errors++;
        $display("FAIL %s: item for cycle %0d not checked (now %0d)", e.tag, e.cyc, cyc);
      end else if (ace !== e.ce || apr !== e.pr || adn !== e.dn || ardy !== e.rdy || absy !== !e.rdy) begin
        errors++;
        $display("FAIL %s dut%0d cyc %0d: ce/pr/done/ready/busy actual %b%b%b%b%b expected %b%b%b%b%b",
                 e.tag, e.which, cyc, ace, apr, adn, ardy, absy, e.ce, e.pr, e.dn, e.rdy, !e.rdy);
      end
    end
  end

  task automatic push(input int base, input int k, input int w,
                      input bit ce, input bit pr, input bit dn, input bit rdy, input string tag);
    exp_t e;
    e.cyc = base + k; e.which = w; e.ce = ce; e.pr = pr; e.dn = dn; e.rdy = rdy; e.tag = tag;
    q.push_back(e);
  endtask

  // Align to a falling edge; base is the cycle index seen after the accepting edge E0
  task automatic open_req(output int base);
    @(negedge clk);
    base = cyc + 1;
  endtask

  task automatic fire(input int w, input bit en, input bit dis);
    if (w == 0) begin en0 = en; dis0 = dis; end else begin en1 = en; dis1 = dis; end
    @(negedge clk);
    en0 = 1'b0; dis0 = 1'b0; en1 = 1'b0; dis1 = 1'b0;
  endtask

  task automatic pulse_at(input int c, input int w, input bit en, input bit dis);
    while (cyc < c) @(negedge clk);
    fire(w, en, dis);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of both channels
    open_req(b);
    push(b, 0, 0, 1, 1, 0, 1, "R1");
    push(b, 0, 1, 0, 0, 0, 1, "R1");
    drain();

    // R5: clock running with reset held -> full sequence; R9: disable during busy ignored
    open_req(b);
    push(b, 0,         0, 1, 1, 0, 0, "R5");
    push(b, 4,         0, 1, 1, 0, 0, "R9");
    push(b, 2+S,       0, 1, 1, 0, 0, "R5");
    push(b, 2+S+L,     0, 1, 1, 0, 0, "R5");
    push(b, 3+S+L,     0, 1, 0, 1, 0, "R5");
    push(b, 4+S+L,     0, 1, 0, 0, 1, "R8");
    fire(0, 1, 0);
    pulse_at(b + 2, 0, 0, 1);
    drain();

    // R7: disable clears clock, reset untouched
    open_req(b);
    push(b, 0, 0, 0, 0, 1, 0, "R7");
    push(b, 1, 0, 0, 0, 0, 1, "R8");
    fire(0, 0, 1);
    drain();

    // R2/R3: fresh enable from clock stopped; R9: enable during busy ignored
    open_req(b);
    push(b, 0,         0, 0, 0, 0, 0, "R9");
    push(b, 1,         0, 0, 1, 0, 0, "R2");
    push(b, 1+S,       0, 0, 1, 0, 0, "R2");
    push(b, 2+S,       0, 1, 1, 0, 0, "R2");
    push(b, 9,         0, 1, 1, 0, 0, "R9");
    push(b, 2+S+L,     0, 1, 1, 0, 0, "R3");
    push(b, 3+S+L,     0, 1, 0, 1, 0, "R3");
    push(b, 4+S+L,     0, 1, 0, 0, 1, "R8");
    fire(0, 1, 0);
    pulse_at(b + 7, 0, 1, 0);
    drain();

    // R4: enable on an enabled channel completes at once
    open_req(b);
    push(b, 0, 0, 1, 0, 1, 0, "R4");
    push(b, 1, 0, 1, 0, 0, 1, "R4");
    fire(0, 1, 0);
    drain();

    // R10: enable and disable together -> disable
    open_req(b);
    push(b, 0, 0, 0, 0, 1, 0, "R10");
    push(b, 1, 0, 0, 0, 0, 1, "R10");
    fire(0, 1, 1);
    drain();

    // R6: channel without reset line
    open_req(b);
    push(b, 0, 1, 0, 0, 0, 0, "R6");
    push(b, 1, 1, 1, 0, 1, 0, "R6");
    push(b, 2, 1, 1, 0, 0, 1, "R6");
    fire(1, 1, 0);
    drain();

    // R4 on channel without reset line
    open_req(b);
    push(b, 0, 1, 1, 0, 1, 0, "R4");
    push(b, 1, 1, 1, 0, 0, 1, "R4");
    fire(1, 1, 0);
    drain();

    // R7 on channel without reset line
    open_req(b);
    push(b, 0, 1, 0, 0, 1, 0, "R7");
    push(b, 1, 1, 0, 0, 0, 1, "R7");
    fire(1, 0, 1);
    drain();

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200_000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule